// File: doc/BRIEF.md
# SPI-Mode Memory Card Command Engine

This block plays the card side of a memory card wired in SPI mode, one byte at a time. A byte-level serial front end outside the block handles the full-duplex exchanges. For each exchange it shows the host byte on `rx_byte` together with a one-cycle `rx_valid`. At the same moment it shifts out the reply that the block holds on `tx_byte`. The reply for an exchange depends only on the state the block has reached, so `tx_byte` is already valid before the host byte arrives.

The block parses command frames. Each frame is an index byte, four argument bytes sent most significant first, and a trailing check byte that is never examined. When a frame is complete, the block presents the index and argument to a backend port. The backend answers in the same cycle with a length and up to four status or response bytes. From that answer the block builds one of four reply forms: a one-byte status, a two-byte status, a five-byte interface-condition or OCR reply, or a busy-type status. It also takes in write data blocks and passes their bytes to the backend, and it turns a stop token into an internal stop command. When a plain command ends and the backend has read data waiting, the block hands the link over to a separate read framer. Whenever the block has nothing to send, it returns 0xFF.

Top module: `spi_card_cmd_engine`

## Requirements
- R1: In idle, a host byte of 0xFF is a null byte. The reply is 0xFF, no backend request is made, and the block stays idle.
- R2: In idle, any host byte other than 0xFF, 0xFE, 0xFC or 0xFD opens a command frame. Bits 5:0 of that byte become the command index. The next four bytes form the argument, most significant byte first. The fifth byte is a check byte whose value is ignored, and its exchange raises `be_req_valid` with the index and the argument.
- R3: The exchange right after the request always returns 0xFF. The first reply byte comes on the exchange after that.
- R4: A backend length of 0 (failure) gives the single reply byte 0x04. So does any length other than 4 for commands other than 8 and 58.
- R5: Commands 8 and 58 with a nonzero backend length reply with five bytes: 0x01, then `be_rsp_data[31:24]`, `[23:16]`, `[15:8]` and `[7:0]`.
- R6: Command 13 replies with the 16-bit status word, high byte first. Every other successful command replies with the high byte only.
- R7: Status word encoding, with S meaning `be_rsp_data`. Bit 8 is set when S[12:9] < 4. Bit 10 copies S[22]. Bit 0 copies S[25]. Bit 14 is set when any of status bits 7:0 is set. Bits 1 to 7, 9 and 11 to 13 carry the remaining card error flags.
- R8: After the last reply byte, the block returns one more 0xFF and goes idle. On that closing exchange, `rd_start` pulses if `rd_avail` is high and the command was not a busy type.
- R9: Commands 28, 29 and 38 are busy types. Their closing exchange never raises `rd_start`.
- R10: In idle, 0xFE or 0xFC starts a write block. Each following byte goes out on `wr_valid`/`wr_data`. The block ends after 512 bytes, or after the first byte during which `wr_ready` is low. It then skips exactly two check bytes (reply 0xFF), replies 0x05, closes with 0xFF, and never raises `rd_start`.
- R11: In idle, 0xFD requests command 12 with argument 0 on the backend. The next exchange replies 0x00 if the backend length is 0 and 0xFF otherwise. The exchange after that closes with 0xFF and no `rd_start`.
- R12: While `cs_n` is high, `tx_byte` is 0xFF, host bytes are ignored and no backend or write strobe rises. The block returns to idle with all frame and block counters cleared.
- R13: After reset, the block is idle with `tx_byte` at 0xFF and no strobe raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip select |
| rx_valid | input | 1 | One-cycle strobe: host byte of an exchange present |
| rx_byte | input | 8 | Host byte |
| tx_byte | output | 8 | Reply byte for the current exchange |
| be_req_valid | output | 1 | Backend command request strobe |
| be_req_cmd | output | 6 | Command index of the request |
| be_req_arg | output | 32 | Command argument of the request |
| be_rsp_len | input | LEN_W | Backend response length in bytes, 0 = failure or busy |
| be_rsp_data | input | 32 | Backend response bytes, first byte in bits 31:24 |
| wr_valid | output | 1 | Write data byte strobe |
| wr_data | output | 8 | Write data byte |
| wr_ready | input | 1 | Backend can take bytes after the current one |
| rd_avail | input | 1 | Backend has read data for the read framer |
| rd_start | output | 1 | Hand the link to the read framer |

## Verification
Command frames are sent with several indices. Some index bytes have high bits set, to show that only bits 5:0 count. The same frame is also sent with different check bytes, to show that the check byte has no effect. The backend answers are chosen to separate every reply form: failure, a wrong length, a five-byte reply, a two-byte status and a one-byte status. Among the status words, an idle card state, error bits in the high byte, and a low-byte flag that sets the parameter-error bit expose each encoding rule. Write blocks end once by backend back-pressure and once by the 512-byte count. The stop token is tried with a busy backend and with a ready one. Chip select is pulled mid-argument and mid-reply, to show that no stale counter or reply survives.

// File: rtl/spicard_pkg.sv
package spicard_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_ARG   = 3'd1,
      ST_CRC   = 3'd2,
      ST_GAP   = 3'd3,
      ST_RESP  = 3'd4,
      ST_WDATA = 3'd5,
      ST_WCRC  = 3'd6
   } step_e;

   localparam logic [7:0] FILL         = 8'hFF;
   localparam logic [7:0] TOK_BLOCK    = 8'hFE;
   localparam logic [7:0] TOK_MULTI    = 8'hFC;
   localparam logic [7:0] TOK_STOP     = 8'hFD;
   localparam logic [7:0] REPLY_BAD    = 8'h04;
   localparam logic [7:0] REPLY_LONG   = 8'h01;
   localparam logic [7:0] REPLY_WR_OK  = 8'h05;
   localparam logic [7:0] REPLY_BUSY   = 8'h00;

   localparam logic [5:0] IDX_STOP     = 6'd12;
   localparam logic [5:0] IDX_STATUS   = 6'd13;
   localparam logic [5:0] IDX_IFCOND   = 6'd8;
   localparam logic [5:0] IDX_OCR      = 6'd58;
   localparam logic [5:0] IDX_BUSY_A   = 6'd28;
   localparam logic [5:0] IDX_BUSY_B   = 6'd29;
   localparam logic [5:0] IDX_BUSY_C   = 6'd38;

   localparam int REPLY_SLOTS = 5;
   localparam int ARG_BYTES   = 4;
   localparam int CRC_SKIP    = 2;

endpackage

// File: rtl/spicard_status_map.sv
module spicard_status_map #(
   parameter bit PARAM_ERR_EN = 1'b1
) (
   input  logic [31:0] card_st,
   output logic [15:0] word
);
   localparam int IDLE_LIMIT = 4;

   logic [13:0] base;

   always_comb begin
      base     = '0;
      base[0]  = card_st[25];
      base[1]  = card_st[24] | card_st[15];
      base[2]  = card_st[19];
      base[3]  = card_st[20];
      base[4]  = card_st[21];
      base[5]  = card_st[26];
      base[6]  = card_st[27];
      base[7]  = card_st[31] | card_st[16];
      base[8]  = (card_st[12:9] < 4'(IDLE_LIMIT));
      base[9]  = card_st[13];
      base[10] = card_st[22];
      base[11] = card_st[23];
      base[12] = card_st[28];
      base[13] = card_st[30];
   end

   generate
      if (PARAM_ERR_EN) begin : g_param_err
         assign word = {1'b0, |base[7:0], base};
      end else begin : g_no_param_err
         assign word = {2'b00, base};
      end
   endgenerate

   logic unused_bits;
   assign unused_bits = ^{card_st[8:0], card_st[14], card_st[18:17], card_st[29]};

endmodule

// File: rtl/spicard_step_cnt.sv
module spicard_step_cnt #(
   parameter int LIMIT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic step,
   output logic at_last
);
   localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;

   generate
      if (LIMIT < 2) begin : g_bad_limit
         $error("spicard_step_cnt: LIMIT must be at least 2");
      end
   endgenerate

   logic [W-1:0] cnt;

   assign at_last = (cnt == W'(LIMIT - 1));

   always_ff @(posedge clk) begin
      if (!rst_n)      cnt <= '0;
      else if (clr)    cnt <= '0;
      else if (step)   cnt <= at_last ? '0 : cnt + W'(1);
   end

endmodule

// File: rtl/spicard_reply_buf.sv
module spicard_reply_buf #(
   parameter int DEPTH = 5,
   parameter int PW    = $clog2(DEPTH + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clr,
   input  logic                  load,
   input  logic [DEPTH-1:0][7:0] load_bytes,
   input  logic [PW-1:0]         load_len,
   input  logic                  advance,
   output logic [7:0]            cur,
   output logic                  drained
);
   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("spicard_reply_buf: DEPTH must be positive");
      end
   endgenerate

   logic [DEPTH-1:0][7:0] slots;
   logic [PW-1:0]         len_q;
   logic [PW-1:0]         pos_q;

   assign drained = (pos_q == len_q);

   always_comb begin
      cur = 8'hFF;
      for (int i = 0; i < DEPTH; i++) begin
         if (pos_q == PW'(i)) cur = slots[i];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         slots <= '0;
         len_q <= '0;
         pos_q <= '0;
      end else if (load) begin
         slots <= load_bytes;
         len_q <= load_len;
         pos_q <= '0;
      end else if (advance) begin
         pos_q <= pos_q + PW'(1);
      end
   end

endmodule

// File: rtl/spi_card_cmd_engine.sv
module spi_card_cmd_engine
   import spicard_pkg::*;
#(
   parameter int BLOCK_BYTES  = 512,
   parameter int LEN_W        = 5,
   parameter bit PARAM_ERR_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_n,
   input  logic             rx_valid,
   input  logic [7:0]       rx_byte,
   output logic [7:0]       tx_byte,
   output logic             be_req_valid,
   output logic [5:0]       be_req_cmd,
   output logic [31:0]      be_req_arg,
   input  logic [LEN_W-1:0] be_rsp_len,
   input  logic [31:0]      be_rsp_data,
   output logic             wr_valid,
   output logic [7:0]       wr_data,
   input  logic             wr_ready,
   input  logic             rd_avail,
   output logic             rd_start
);
   localparam int PW = $clog2(REPLY_SLOTS + 1);

   generate
      if (BLOCK_BYTES < 2) begin : g_bad_block
         $error("spi_card_cmd_engine: BLOCK_BYTES must be at least 2");
      end
      if (LEN_W < 3) begin : g_bad_len
         $error("spi_card_cmd_engine: LEN_W must hold the value 4");
      end
   endgenerate

   step_e       st_q, st_d;
   logic [5:0]  cmd_q;
   logic [31:0] arg_q;
   logic        skip_rd_q;
   logic        st_idle;
   logic        act;

   assign act     = rx_valid & ~cs_n;
   assign st_idle = (st_q == ST_IDLE);

   // counters for the frame, the write block and the skipped check bytes
   logic arg_last, wr_last, crc_last, wr_end;

   spicard_step_cnt #(.LIMIT(ARG_BYTES)) u_arg_cnt (
      .clk(clk), .rst_n(rst_n), .clr(cs_n),
      .step(act && st_q == ST_ARG), .at_last(arg_last));

   spicard_step_cnt #(.LIMIT(BLOCK_BYTES)) u_wr_cnt (
      .clk(clk), .rst_n(rst_n), .clr(cs_n | wr_end),
      .step(wr_valid), .at_last(wr_last));

   spicard_step_cnt #(.LIMIT(CRC_SKIP)) u_crc_cnt (
      .clk(clk), .rst_n(rst_n), .clr(cs_n),
      .step(act && st_q == ST_WCRC), .at_last(crc_last));

   // backend request
   logic is_stop, is_exec;
   assign is_stop      = act && st_idle && (rx_byte == TOK_STOP);
   assign is_exec      = act && (st_q == ST_CRC);
   assign be_req_valid = is_stop | is_exec;
   assign be_req_cmd   = is_stop ? IDX_STOP : cmd_q;
   assign be_req_arg   = is_stop ? 32'd0 : arg_q;

   // write path
   assign wr_valid = act && (st_q == ST_WDATA);
   assign wr_data  = rx_byte;
   assign wr_end   = wr_valid && (!wr_ready || wr_last);

   // status word
   logic [15:0] st_word;
   spicard_status_map #(.PARAM_ERR_EN(PARAM_ERR_EN)) u_map (
      .card_st(be_rsp_data), .word(st_word));

   // reply formatting
   logic [REPLY_SLOTS-1:0][7:0] ld_bytes;
   logic [PW-1:0]               ld_len;
   logic                        ld_busy;
   logic                        ld_go;
   logic                        len_zero, len_four, idx_long, idx_busy;

   assign len_zero = (be_rsp_len == '0);
   assign len_four = (be_rsp_len == LEN_W'(4));
   assign idx_long = (cmd_q == IDX_IFCOND) || (cmd_q == IDX_OCR);
   assign idx_busy = (cmd_q == IDX_BUSY_A) || (cmd_q == IDX_BUSY_B) ||
                     (cmd_q == IDX_BUSY_C);

   always_comb begin
      ld_bytes = {REPLY_SLOTS{FILL}};
      ld_len   = PW'(1);
      ld_busy  = 1'b0;
      if (is_stop) begin
         ld_bytes[0] = len_zero ? REPLY_BUSY : FILL;
         ld_busy     = 1'b1;
      end else if (st_q == ST_WCRC) begin
         ld_bytes[0] = REPLY_WR_OK;
         ld_busy     = 1'b1;
      end else if (len_zero) begin
         ld_bytes[0] = REPLY_BAD;
      end else if (idx_long) begin
         ld_len      = PW'(5);
         ld_bytes[0] = REPLY_LONG;
         ld_bytes[1] = be_rsp_data[31:24];
         ld_bytes[2] = be_rsp_data[23:16];
         ld_bytes[3] = be_rsp_data[15:8];
         ld_bytes[4] = be_rsp_data[7:0];
      end else if (!len_four) begin
         ld_bytes[0] = REPLY_BAD;
      end else begin
         ld_len      = (cmd_q == IDX_STATUS) ? PW'(2) : PW'(1);
         ld_bytes[0] = st_word[15:8];
         ld_bytes[1] = st_word[7:0];
         ld_busy     = idx_busy;
      end
   end

   assign ld_go = is_stop || is_exec || (act && st_q == ST_WCRC && crc_last);

   logic [7:0] buf_cur;
   logic       buf_drained;
   logic       buf_adv;

   assign buf_adv = act && (st_q == ST_RESP) && !buf_drained;

   spicard_reply_buf #(.DEPTH(REPLY_SLOTS), .PW(PW)) u_reply (
      .clk(clk), .rst_n(rst_n), .clr(cs_n),
      .load(ld_go), .load_bytes(ld_bytes), .load_len(ld_len),
      .advance(buf_adv), .cur(buf_cur), .drained(buf_drained));

   assign rd_start = act && (st_q == ST_RESP) && buf_drained && !skip_rd_q && rd_avail;

   assign tx_byte = cs_n ? FILL :
                    ((st_q == ST_RESP) && !buf_drained) ? buf_cur : FILL;

   // step machine
   always_comb begin
      st_d = st_q;
      if (cs_n) begin
         st_d = ST_IDLE;
      end else if (act) begin
         case (st_q)
            ST_IDLE: begin
               if (rx_byte == TOK_BLOCK || rx_byte == TOK_MULTI) st_d = ST_WDATA;
               else if (rx_byte == TOK_STOP)                     st_d = ST_RESP;
               else if (rx_byte != FILL)                         st_d = ST_ARG;
            end
            ST_ARG:   if (arg_last) st_d = ST_CRC;
            ST_CRC:   st_d = ST_GAP;
            ST_GAP:   st_d = ST_RESP;
            ST_RESP:  if (buf_drained) st_d = ST_IDLE;
            ST_WDATA: if (wr_end) st_d = ST_WCRC;
            ST_WCRC:  if (crc_last) st_d = ST_RESP;
            default:  st_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         cmd_q     <= '0;
         arg_q     <= '0;
         skip_rd_q <= 1'b0;
      end else if (cs_n) begin
         st_q      <= ST_IDLE;
         cmd_q     <= '0;
         arg_q     <= '0;
         skip_rd_q <= 1'b0;
      end else begin
         st_q <= st_d;
         if (act && st_idle && st_d == ST_ARG) cmd_q <= rx_byte[5:0];
         if (act && st_q == ST_ARG)            arg_q <= {arg_q[23:0], rx_byte};
         if (ld_go)                            skip_rd_q <= ld_busy;
      end
   end

endmodule

// File: rtl/spicard_checker.sv
module spicard_checker (
   input logic        clk,
   input logic        rst_n,
   input logic        cs_n,
   input logic        rx_valid,
   input logic [7:0]  rx_byte,
   input logic [7:0]  tx_byte,
   input logic        be_req_valid,
   input logic        wr_valid,
   input logic        wr_ready,
   input logic        rd_start,
   input logic        st_idle
);
   // R1: a null byte in idle keeps the block idle
   a_r1_null_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && rx_valid && st_idle && rx_byte == 8'hFF) |=> st_idle);

   // R3: the exchange after a command request returns filler
   a_r3_gap_filler: assert property (@(posedge clk) disable iff (!rst_n)
      (be_req_valid && !st_idle) |=> (tx_byte == 8'hFF));

   // R8: at most one of request, write byte, hand-off per cycle
   a_r8_one_action: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({be_req_valid, wr_valid, rd_start}));

   // R10: back-pressure ends the write block
   a_r10_wr_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !wr_ready) |=> !wr_valid);

   // R11: the stop token leaves idle for its reply
   a_r11_stop_reply: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && rx_valid && st_idle && rx_byte == 8'hFD) |=> !st_idle);

   // R12: deselected block is silent
   a_r12_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> (tx_byte == 8'hFF && !be_req_valid && !wr_valid && !rd_start));

   // R12: deselect returns to idle
   a_r12_deselect_idle: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> st_idle);
endmodule

bind spi_card_cmd_engine spicard_checker u_chk (
   .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rx_valid(rx_valid),
   .rx_byte(rx_byte), .tx_byte(tx_byte), .be_req_valid(be_req_valid),
   .wr_valid(wr_valid), .wr_ready(wr_ready), .rd_start(rd_start),
   .st_idle(st_idle));

// File: tb/tb_spi_card_cmd_engine.sv
`timescale 1ns/1ps
module tb_spi_card_cmd_engine;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_byte = 8'hFF;
   logic [7:0]  tx_byte;
   logic        be_req_valid;
   logic [5:0]  be_req_cmd;
   logic [31:0] be_req_arg;
   logic [4:0]  bk_len = 5'd4;
   logic [31:0] bk_data = 32'd0;
   logic        wr_valid;
   logic [7:0]  wr_data;
   logic        wr_ready;
   logic        rd_avail = 1'b0;
   logic        rd_start;

   int n_chk = 0, n_fail = 0;
   int req_cnt = 0, wr_got = 0, wr_limit = 1000000;
   int wr_sum = 0;
   logic [5:0]  last_cmd = '0;
   logic [31:0] last_arg = '0;
   bit          done = 1'b0;

   logic [7:0] exp_q[$];
   bit         exprd_q[$];
   string      tag_q[$];

   always #2 clk = ~clk;

   assign wr_ready = (wr_got < wr_limit);

   spi_card_cmd_engine dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rx_valid(rx_valid),
      .rx_byte(rx_byte), .tx_byte(tx_byte), .be_req_valid(be_req_valid),
      .be_req_cmd(be_req_cmd), .be_req_arg(be_req_arg), .be_rsp_len(bk_len),
      .be_rsp_data(bk_data), .wr_valid(wr_valid), .wr_data(wr_data),
      .wr_ready(wr_ready), .rd_avail(rd_avail), .rd_start(rd_start));

   task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // backend model log and scoreboard monitor, both away from the active edge
   always @(negedge clk) begin
      if (be_req_valid) begin
         req_cnt++;
         last_cmd = be_req_cmd;
         last_arg = be_req_arg;
      end
      if (wr_valid) begin
         wr_got++;
         wr_sum += int'(wr_data);
      end
      if (rx_valid) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "scoreboard underflow", 32'(tx_byte), 32'hFF);
         end else begin
            logic [7:0] e;
            bit         er;
            string      t;
            e  = exp_q.pop_front();
            er = exprd_q.pop_front();
            t  = tag_q.pop_front();
            chk(tx_byte == e, t, 32'(tx_byte), 32'(e));
            chk(rd_start == er, {t, " rd_start"}, 32'(rd_start), 32'(er));
         end
      end
   end

   task automatic xfer(logic [7:0] b, logic [7:0] e, bit r, string t);
      exp_q.push_back(e);
      exprd_q.push_back(r);
      tag_q.push_back(t);
      @(posedge clk); #1;
      rx_byte  = b;
      rx_valid = 1'b1;
      @(posedge clk); #1;
      rx_valid = 1'b0;
   endtask

   // full frame plus the filler exchange after the request
   task automatic frame(logic [7:0] c, logic [31:0] a, logic [7:0] crc, string t);
      xfer(c, 8'hFF, 1'b0, t);
      for (int i = 0; i < 4; i++) xfer(a[31-8*i -: 8], 8'hFF, 1'b0, t);
      xfer(crc, 8'hFF, 1'b0, t);
      xfer(8'hFF, 8'hFF, 1'b0, {t, " gap"});
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(4 * 150000);
      chk(1'b0, "watchdog expired", 32'd0, 32'd1);
      finish_up();
   end

   initial begin
      int base;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1; cs_n = 1'b0;
      @(negedge clk);
      // R13 reset state
      chk(tx_byte == 8'hFF, "R13 tx after reset", 32'(tx_byte), 32'hFF);
      chk(!be_req_valid && !wr_valid && !rd_start, "R13 strobes after reset",
          32'({be_req_valid, wr_valid, rd_start}), 32'd0);

      // R1 null bytes
      for (int i = 0; i < 3; i++) xfer(8'hFF, 8'hFF, 1'b0, "R1 null");
      chk(req_cnt == 0, "R1 no request", req_cnt, 0);

      // R2 R3 R7 idle status, one byte
      bk_len = 5'd4; bk_data = 32'h0000_0000;
      frame(8'h40, 32'h0000_0000, 8'h95, "R3 cmd0");
      xfer(8'hFF, 8'h01, 1'b0, "R7 idle bit");
      xfer(8'hFF, 8'hFF, 1'b0, "R8 close");
      chk(req_cnt == 1 && last_cmd == 6'd0, "R2 cmd0 request", last_cmd, 0);

      // R6 R7 two-byte status, argument order
      bk_data = 32'h0240_0800;
      frame(8'h4D, 32'h1234_5678, 8'h00, "R2 cmd13");
      chk(last_cmd == 6'd13, "R2 index", last_cmd, 13);
      chk(last_arg == 32'h1234_5678, "R2 argument msb first", last_arg, 32'h1234_5678);
      xfer(8'hFF, 8'h44, 1'b0, "R6 status high");
      xfer(8'hFF, 8'h01, 1'b0, "R6 status low");
      xfer(8'hFF, 8'hFF, 1'b0, "R8 close");
      // same frame, high index bits and other check byte
      frame(8'hCD, 32'h1234_5678, 8'hAB, "R2 crc ignored");
      chk(last_cmd == 6'd13, "R2 low six bits", last_cmd, 13);
      xfer(8'hFF, 8'h44, 1'b0, "R2 crc ignored hi");
      xfer(8'hFF, 8'h01, 1'b0, "R2 crc ignored lo");
      xfer(8'hFF, 8'hFF, 1'b0, "R8 close");

      // R5 long replies
      bk_data = 32'h0000_01AA;
      frame(8'h48, 32'h0000_01AA, 8'h87, "R5 cmd8");
      xfer(8'hFF, 8'h01, 1'b0, "R5 cmd8 b0");
      xfer(8'hFF, 8'h00, 1'b0, "R5 cmd8 b1");
      xfer(8'hFF, 8'h00, 1'b0, "R5 cmd8 b2");
      xfer(8'hFF, 8'h01, 1'b0, "R5 cmd8 b3");
      xfer(8'hFF, 8'hAA, 1'b0, "R5 cmd8 b4");
      xfer(8'hFF, 8'hFF, 1'b0, "R8 close");
      bk_len = 5'd16; bk_data = 32'hC0FF_8000;
      frame(8'h7A, 32'h0, 8'h00, "R5 cmd58");
      xfer(8'hFF, 8'h01, 1'b0, "R5 cmd58 b0");
      xfer(8'hFF, 8'hC0, 1'b0, "R5 cmd58 b1");
      xfer(8'hFF, 8'hFF, 1'b0, "R5 cmd58 b2");
      xfer(8'hFF, 8'h80, 1'b0, "R5 cmd58 b3");
      xfer(8'hFF, 8'h00, 1'b0, "R5 cmd58 b4");
      xfer(8'hFF, 8'hFF, 1'b0, "R8 close");

      // R4 failure and wrong length
      bk_len = 5'd0;
      frame(8'h51, 32'h0, 8'h00, "R4 fail");
      xfer(8'hFF, 8'h04, 1'b0, "R4 fail reply");
      xfer(8'hFF, 8'hFF, 1'b0, "R8 close");
      bk_len = 5'd16;
      frame(8'h49, 32'h0, 8'h00, "R4 length");
      xfer(8'hFF, 8'h04, 1'b0, "R4 length reply");
      xfer(8'hFF, 8'hFF, 1'b0, "R8 close");

      // R8 R9 read hand-off
      bk_len = 5'd4; bk_data = 32'h0000_0800; rd_avail = 1'b1;
      frame(8'h51, 32'h200, 8'h00, "R8 cmd17");
      xfer(8'hFF, 8'h00, 1'b0, "R8 cmd17 status");
      xfer(8'hFF, 8'hFF, 1'b1, "R8 handoff");
      frame(8'h66, 32'h0, 8'h00, "R9 cmd38");
      xfer(8'hFF, 8'h00, 1'b0, "R9 cmd38 status");
      xfer(8'hFF, 8'hFF, 1'b0, "R9 busy no handoff");
      frame(8'h5C, 32'h0, 8'h00, "R9 cmd28");
      xfer(8'hFF, 8'h00, 1'b0, "R9 cmd28 status");
      xfer(8'hFF, 8'hFF, 1'b0, "R9 busy no handoff");

      // R11 stop token
      bk_len = 5'd0; base = req_cnt;
      xfer(8'hFD, 8'hFF, 1'b0, "R11 stop busy");
      chk(req_cnt == base + 1 && last_cmd == 6'd12 && last_arg == 0,
          "R11 stop request", last_cmd, 12);
      xfer(8'hFF, 8'h00, 1'b0, "R11 busy reply");
      xfer(8'hFF, 8'hFF, 1'b0, "R11 close");
      bk_len = 5'd4;
      xfer(8'hFD, 8'hFF, 1'b0, "R11 stop ready");
      xfer(8'hFF, 8'hFF, 1'b0, "R11 ready reply");
      xfer(8'hFF, 8'hFF, 1'b0, "R11 close");
      rd_avail = 1'b0;

      // R10 short write by back-pressure
      wr_got = 0; wr_sum = 0; wr_limit = 3;
      xfer(8'hFE, 8'hFF, 1'b0, "R10 token");
      xfer(8'hA1, 8'hFF, 1'b0, "R10 data");
      xfer(8'hA2, 8'hFF, 1'b0, "R10 data");
      xfer(8'hA3, 8'hFF, 1'b0, "R10 data");
      xfer(8'h11, 8'hFF, 1'b0, "R10 crc skip");
      xfer(8'h22, 8'hFF, 1'b0, "R10 crc skip");
      xfer(8'hFF, 8'h05, 1'b0, "R10 accepted");
      xfer(8'hFF, 8'hFF, 1'b0, "R10 close");
      chk(wr_got == 3, "R10 short count", wr_got, 3);
      chk(wr_sum == 'hA1 + 'hA2 + 'hA3, "R10 short data", wr_sum, 'hA1 + 'hA2 + 'hA3);

      // R10 full block ends on count
      wr_got = 0; wr_limit = 1000000; rd_avail = 1'b1;
      xfer(8'hFC, 8'hFF, 1'b0, "R10 multi token");
      for (int i = 0; i < 512; i++) xfer(8'(i), 8'hFF, 1'b0, "R10 block data");
      xfer(8'h33, 8'hFF, 1'b0, "R10 crc skip");
      xfer(8'h44, 8'hFF, 1'b0, "R10 crc skip");
      xfer(8'hFF, 8'h05, 1'b0, "R10 accepted");
      xfer(8'hFF, 8'hFF, 1'b0, "R10 close no handoff");
      chk(wr_got == 512, "R10 block count", wr_got, 512);
      rd_avail = 1'b0;

      // R12 deselect mid argument clears counters
      base = req_cnt;
      xfer(8'h40, 8'hFF, 1'b0, "R12 partial");
      xfer(8'h55, 8'hFF, 1'b0, "R12 partial");
      xfer(8'h66, 8'hFF, 1'b0, "R12 partial");
      cs_n = 1'b1;
      xfer(8'h77, 8'hFF, 1'b0, "R12 ignored");
      xfer(8'h88, 8'hFF, 1'b0, "R12 ignored");
      chk(req_cnt == base, "R12 no request while deselected", req_cnt, base);
      cs_n = 1'b0;
      bk_len = 5'd4; bk_data = 32'h0;
      frame(8'h40, 32'hDEAD_BEEF, 8'h00, "R12 fresh frame");
      chk(last_arg == 32'hDEAD_BEEF, "R12 counter cleared", last_arg, 32'hDEAD_BEEF);
      // deselect in the middle of a reply
      cs_n = 1'b1;
      @(negedge clk);
      chk(tx_byte == 8'hFF, "R12 tx while deselected", 32'(tx_byte), 32'hFF);
      @(posedge clk); #1 cs_n = 1'b0;
      xfer(8'hFF, 8'hFF, 1'b0, "R12 reply dropped");
      chk(req_cnt == base + 1, "R12 idle after reselect", req_cnt, base + 1);

      repeat (4) @(posedge clk);
      finish_up();
   end
endmodule